// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter with Low-Power Parking

This block decides which of several master ports owns one slave port of a multi-master crossbar. Each master raises a request line. The arbiter grants the port to one of them and keeps that grant until the slave side reports the end of the transaction. Every other requester waits. A configuration input selects the arbitration policy at run time. In fixed-priority mode the lowest master index wins. In round-robin mode the search starts just after the last master that was granted.

When nobody owns the port and no request is pending, the port is parked. While parked, the slave-side address, write-data and control outputs are held at zero so that they do not toggle, and a status output flags the state. Leaving the parked state costs one extra arbitration cycle before the first grant. A hand-over from one owner straight to the next costs no such cycle.

Top module: `xbar_port_arb`

## Requirements
- R1: At most one bit of `mGrant` is set in any cycle, and a newly set grant bit belongs to a master whose request was high at the arbitration edge.
- R2: With `rrMode` low at an arbitration point, the requesting master with the lowest index is granted.
- R3: While an owner holds the port and `xferDone` is low, `mGrant` does not change, whatever the other masters request.
- R4: With `rrMode` high at an arbitration point, the grant goes to the first requester after the last-granted master index, counting upward and wrapping from 5 to 0. With all six masters requesting and `xferDone` high every cycle, the grants rotate 0,1,2,3,4,5,0,...
- R5: After reset `parked` is 1, `mGrant` is 0, `sValid` is 0, and `sAddr`, `sWdata` and `sWrite` are 0.
- R6: Whenever no master owns the port, `sAddr`, `sWdata` and `sWrite` are all zero and `sValid` is 0. When `parked` is 1, `mGrant` is also 0.
- R7: A request seen at an edge while parked clears `parked` after that edge with no grant yet. The grant appears after the following edge, so the wake costs exactly one cycle. If no request is present at that second edge, the port parks again.
- R8: An edge where `xferDone` is high for an owner and no master requests returns the port to parked. An edge where `xferDone` is high and some master requests hands the port directly to the winner, with no wake cycle.
- R9: The last-granted index resets to 5, so the first round-robin grant after reset with all masters requesting goes to master 0.
- R10: A change of `rrMode` during an ownership does not disturb the current grant. It only affects the next arbitration point.
- R11: While a master owns the port, `sAddr`, `sWdata` and `sWrite` equal that master's slices of `mAddr`, `mWdata` and `mWrite` (master i at bits i*32, i*64 and bit i).
- R12: `xferDone` has no effect when no master owns the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rrMode | input | 1 | 1 selects round-robin, 0 selects fixed priority (master 0 highest) |
| mReq | input | 6 | Request line of each master |
| xferDone | input | 1 | The owner's transaction completes at this edge |
| mAddr | input | 192 | Address of each master, 32 bits per master |
| mWdata | input | 384 | Write data of each master, 64 bits per master |
| mWrite | input | 6 | Write/read control bit of each master |
| mGrant | output | 6 | One-hot ownership grant |
| parked | output | 1 | Port is in the low-power parked state |
| sValid | output | 1 | A master owns the port |
| sAddr | output | 32 | Slave-side address, zero when unowned |
| sWdata | output | 64 | Slave-side write data, zero when unowned |
| sWrite | output | 1 | Slave-side control bit, zero when unowned |

## Verification
Ownership and the parked flag are registered. A request or a `xferDone` applied before edge N shows on `mGrant`, `sValid` and `parked` just after edge N. The one exception is a wake from park, where the grant appears only after edge N+1. The slave-side outputs are a combinational view of the current owner's inputs, so they follow input changes within the same cycle. The bench drives inputs on the falling edge and updates a reference model for the coming rising edge. It compares all outputs at the next falling edge, while the inputs that produced them are still applied, so each result is checked in the cycle it is due.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

  typedef enum logic [1:0] {
    PORT_PARK = 2'd0,
    PORT_WAKE = 2'd1,
    PORT_BUSY = 2'd2
  } portState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOwner;  // capture arbitration winner as new owner
    logic dropOwner;  // release ownership
  } arbStrobe_t;

endpackage

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic          rrMode,
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] lastId,
  output logic [IW-1:0] winIdx
);
  localparam logic [IW:0] NW = (IW+1)'(N);

  logic          found;
  logic [IW:0]   sum;
  logic [IW-1:0] cand;

  always_comb begin
    winIdx = '0;
    found  = 1'b0;
    sum    = '0;
    cand   = '0;
    for (int k = 0; k < N; k++) begin
      if (rrMode) begin
        sum = {1'b0, lastId} + (IW+1)'(k + 1);
        if (sum >= NW) sum = sum - NW;
        cand = sum[IW-1:0];
      end else begin
        cand = IW'(k);
      end
      if (!found && req[cand]) begin
        found  = 1'b1;
        winIdx = cand;
      end
    end
  end
endmodule

// File: rtl/xbar_arb_ctrl.sv
module xbar_arb_ctrl
  import xbar_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       xferDone,
  output arbStrobe_t strobe,
  output logic       parked
);
  portState_t state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe.loadOwner = 1'b0;
    strobe.dropOwner = 1'b0;
    case (state)
      PORT_PARK: if (anyReq) stateNext = PORT_WAKE;
      PORT_WAKE: begin
        if (anyReq) begin
          stateNext        = PORT_BUSY;
          strobe.loadOwner = 1'b1;
        end else begin
          stateNext = PORT_PARK;
        end
      end
      PORT_BUSY: begin
        if (xferDone) begin
          if (anyReq) begin
            strobe.loadOwner = 1'b1;
          end else begin
            strobe.dropOwner = 1'b1;
            stateNext        = PORT_PARK;
          end
        end
      end
      default: stateNext = PORT_PARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PORT_PARK;
    else       state <= stateNext;
  end

  assign parked = (state == PORT_PARK);
endmodule

// File: rtl/xbar_arb_data.sv
module xbar_arb_data
  import xbar_arb_pkg::*;
#(
  parameter int N  = 6,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  arbStrobe_t    strobe,
  input  logic          rrMode,
  input  logic [N-1:0]  mReq,
  input  logic [N*AW-1:0] mAddr,
  input  logic [N*DW-1:0] mWdata,
  input  logic [N-1:0]  mWrite,
  output logic [N-1:0]  mGrant,
  output logic          sValid,
  output logic [AW-1:0] sAddr,
  output logic [DW-1:0] sWdata,
  output logic          sWrite
);
  logic [IW-1:0] ownerId, lastId, winIdx;
  logic          ownValid;

  xbar_arb_pick #(.N(N), .IW(IW)) u_pick (
    .rrMode (rrMode),
    .req    (mReq),
    .lastId (lastId),
    .winIdx (winIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerId  <= '0;
      ownValid <= 1'b0;
      lastId   <= IW'(N - 1);
    end else if (strobe.loadOwner) begin
      ownerId  <= winIdx;
      ownValid <= 1'b1;
      lastId   <= winIdx;
    end else if (strobe.dropOwner) begin
      ownValid <= 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign mGrant[g] = ownValid && (ownerId == IW'(g));
  end

  always_comb begin
    sAddr  = '0;
    sWdata = '0;
    sWrite = 1'b0;
    if (ownValid) begin
      sAddr  = mAddr[int'(ownerId)*AW +: AW];
      sWdata = mWdata[int'(ownerId)*DW +: DW];
      sWrite = mWrite[ownerId];
    end
  end

  assign sValid = ownValid;
endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb
  import xbar_arb_pkg::*;
#(
  parameter int N  = 6,
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rrMode,
  input  logic [N-1:0]    mReq,
  input  logic            xferDone,
  input  logic [N*AW-1:0] mAddr,
  input  logic [N*DW-1:0] mWdata,
  input  logic [N-1:0]    mWrite,
  output logic [N-1:0]    mGrant,
  output logic            parked,
  output logic            sValid,
  output logic [AW-1:0]   sAddr,
  output logic [DW-1:0]   sWdata,
  output logic            sWrite
);
  arbStrobe_t strobe;

  xbar_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (|mReq),
    .xferDone (xferDone),
    .strobe   (strobe),
    .parked   (parked)
  );

  xbar_arb_data #(.N(N), .AW(AW), .DW(DW)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rrMode (rrMode),
    .mReq   (mReq),
    .mAddr  (mAddr),
    .mWdata (mWdata),
    .mWrite (mWrite),
    .mGrant (mGrant),
    .sValid (sValid),
    .sAddr  (sAddr),
    .sWdata (sWdata),
    .sWrite (sWrite)
  );
endmodule

// File: rtl/xbar_arb_checker.sv
module xbar_arb_checker #(
  parameter int N  = 6,
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  mReq,
  input logic          xferDone,
  input logic [N-1:0]  mGrant,
  input logic          parked,
  input logic          sValid,
  input logic [AW-1:0] sAddr,
  input logic [DW-1:0] sWdata,
  input logic          sWrite
);
  a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mGrant));

  a_r1_grant_requested: assert property (@(posedge clk) disable iff (!rstN)
    (mGrant != '0 && !$stable(mGrant)) |-> (($past(mReq) & mGrant) != '0));

  a_r3_hold_owner: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && !xferDone) |=> $stable(mGrant));

  a_r6_park_quiet: assert property (@(posedge clk) disable iff (!rstN)
    parked |-> (mGrant == '0 && sAddr == '0 && sWdata == '0 && !sWrite));

  a_r6_unowned_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sValid |-> (sAddr == '0 && sWdata == '0 && !sWrite));

  a_r7_wake_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parked) |-> (mGrant == '0));

  a_r8_repark: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && xferDone && mReq == '0) |=> parked);

  a_r8_direct_handover: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && xferDone && mReq != '0) |=> sValid);
endmodule

bind xbar_port_arb xbar_arb_checker #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mReq     (mReq),
  .xferDone (xferDone),
  .mGrant   (mGrant),
  .parked   (parked),
  .sValid   (sValid),
  .sAddr    (sAddr),
  .sWdata   (sWdata),
  .sWrite   (sWrite)
);

// File: tb/tb_xbar_port_arb.sv
`timescale 1ns/1ps
module tb_xbar_port_arb;
  localparam int N  = 6;
  localparam int AW = 32;
  localparam int DW = 64;

  logic            clk = 1'b0;
  logic            rstN;
  logic            rrMode;
  logic [N-1:0]    mReq;
  logic            xferDone;
  logic [N*AW-1:0] mAddr;
  logic [N*DW-1:0] mWdata;
  logic [N-1:0]    mWrite;
  logic [N-1:0]    mGrant;
  logic            parked, sValid, sWrite;
  logic [AW-1:0]   sAddr;
  logic [DW-1:0]   sWdata;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state: 0 park, 1 wake, 2 busy
  int mState, mOwn, mLast;

  always #2 clk = ~clk;

  xbar_port_arb #(.N(N), .AW(AW), .DW(DW)) dut (.*);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pickWin(logic [N-1:0] req, logic rr, int last);
    for (int k = 0; k < N; k++) begin
      int idx = rr ? (last + 1 + k) % N : k;
      if (req[idx]) return idx;
    end
    return 0;
  endfunction

  task automatic step(input logic [N-1:0] req, input logic done, input logic rr);
    string gTag;
    logic [N-1:0] expG;
    mReq = req; xferDone = done; rrMode = rr;
    for (int i = 0; i < N; i++) begin
      mAddr[i*AW +: AW] = $urandom;
      mWdata[i*DW +: DW] = {$urandom, $urandom};
    end
    mWrite = N'($urandom);
    // model update for the coming edge
    gTag = rr ? "R4" : "R2";
    case (mState)
      0: begin if (req != 0) mState = 1; gTag = "R7"; end
      1: begin
        gTag = "R7";
        if (req != 0) begin mOwn = pickWin(req, rr, mLast); mLast = mOwn; mState = 2; end
        else mState = 0;
      end
      default: begin
        if (!done) gTag = "R3";
        else if (req != 0) begin mOwn = pickWin(req, rr, mLast); mLast = mOwn; end
        else begin mState = 0; gTag = "R8"; end
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    expG = (mState == 2) ? N'(1) << mOwn : '0;
    check(gTag, 128'(mGrant), 128'(expG));
    check("R1", 128'($countones(mGrant) <= 1), 128'(1));
    check(mState == 0 ? "R8" : "R7", 128'(parked), 128'(mState == 0));
    if (mState == 2) begin
      check("R11", 128'({sWrite, sAddr, sWdata}),
            128'({mWrite[mOwn], mAddr[mOwn*AW +: AW], mWdata[mOwn*DW +: DW]}));
    end else begin
      check("R6", 128'({sValid, sWrite, sAddr, sWdata}), 128'(0));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rstN = 1'b0; rrMode = 1'b0; mReq = '0; xferDone = 1'b0;
    mAddr = '0; mWdata = '0; mWrite = '0;
    mState = 0; mOwn = 0; mLast = N - 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5", 128'({parked, sValid, mGrant}), 128'({1'b1, 1'b0, 6'b0}));
    check("R5", 128'({sWrite, sAddr, sWdata}), 128'(0));

    // R9: first round-robin grant after reset with all requesting -> master 0
    step(6'h3F, 1'b0, 1'b1);          // park -> wake
    check("R7", 128'(mGrant), 128'(0));
    step(6'h3F, 1'b0, 1'b1);          // wake -> grant
    check("R9", 128'(mGrant), 128'(6'b000001));

    // R4 fairness: all request, done each cycle
    for (int c = 0; c < 12; c++) begin
      step(6'h3F, 1'b1, 1'b1);
      check("R4", 128'(mGrant), 128'(N'(1) << ((c + 1) % N)));
    end

    // R2 fixed priority under full load
    for (int c = 0; c < 4; c++) step(6'h3F, 1'b1, 1'b0);
    check("R2", 128'(mGrant), 128'(6'b000001));
    step(6'b101100, 1'b1, 1'b0);
    check("R2", 128'(mGrant), 128'(6'b000100));

    // R10 / R3: mode flip and higher-priority request during ownership
    step(6'h3F, 1'b0, 1'b1);
    check("R10", 128'(mGrant), 128'(6'b000100));
    step(6'b000001, 1'b0, 1'b0);
    check("R3", 128'(mGrant), 128'(6'b000100));

    // R8: done with no requests -> park; R12: done ignored while parked
    step(6'b0, 1'b1, 1'b0);
    check("R8", 128'(parked), 128'(1));
    step(6'b0, 1'b1, 1'b0);
    check("R12", 128'({parked, sValid}), 128'(2'b10));

    // R7: wake then abandon -> park again
    step(6'b010000, 1'b1, 1'b0);
    check("R7", 128'({parked, mGrant}), 128'(0));
    step(6'b0, 1'b1, 1'b0);
    check("R7", 128'(parked), 128'(1));

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] r;
      r = ($urandom % 5 == 0) ? '0 : N'($urandom);
      step(r, ($urandom % 3) == 0, ($urandom % 8) < 4);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule